// File: doc/BRIEF.md
# Polarity-Selectable Phase Frequency Detector

This block is the digital comparison stage of a frequency synthesizer loop. It takes the divided reference pulse train and the divided oscillator pulse train and compares them. It drives an "up" and a "down" logic output for an external charge pump. The width of each output pulse is the phase error between the two trains.

A single polarity input sets the sense of the comparison. When it is high, an early reference edge produces "up". When it is low, the two outputs exchange roles, which suits a loop whose oscillator tunes in the opposite direction. The same input also steers a monitor output. Polarity high shows the raw reference-divider signal on the monitor, and polarity low shows the raw main-divider signal. The system intends the polarity input to rest high. It is low only in an inverting loop.

Both inputs are synchronised to the system clock and reduced to single-clock edge pulses. Each pulse sets its own flag. Once both flags are set, they are held together for one clock and then cleared. A lock indicator rises after a programmable run of comparisons in which the leading flag stood alone for no more than a set tolerance. It falls the first time that tolerance is exceeded.

Top module: `pfd_polsel`

## Requirements
- R1: While reset is held and just after it is released, `up_o`, `dn_o` and `lock_o` are all 0.
- R2: With `pol_i` = 1, the reference flag drives `up_o` and the oscillator flag drives `dn_o`. The leading output stays high for d+1 clocks when the lagging input's edge arrives d clocks later.
- R3: Once both flags are set, they clear after exactly one clock. The lagging output is therefore high for exactly one clock.
- R4: With `pol_i` = 0, the roles swap: the reference flag drives `dn_o` and the oscillator flag drives `up_o`.
- R5: `mon_o` equals `ref_div_i` when `pol_i` = 1 and equals `vco_div_i` when `pol_i` = 0, with no clock delay.
- R6: A rising input edge driven between clock edges reaches its flag on the (SYNC_STAGES+1)-th rising clock edge, which is the third edge with the default of 2.
- R7: Only rising input edges set a flag. Falling edges and inputs held at a steady level leave `up_o` and `dn_o` low.
- R8: `lock_o` rises in the clock in which the flags clear at the end of the LOCK_CNT-th consecutive aligned comparison. A comparison is aligned when a single flag was set alone for at most ALIGN_TOL clocks.
- R9: `lock_o` falls in the clock after a flag has stood alone for ALIGN_TOL clocks and is still alone. The misaligned comparison restarts the run count.
- R10: Edges on both inputs in the same clock set both flags together. `up_o` and `dn_o` are then both high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div_i | input | 1 | Reference-divider output, asynchronous |
| vco_div_i | input | 1 | Main (oscillator) divider output, asynchronous |
| pol_i | input | 1 | Polarity select: 1 normal, 0 inverted; also steers the monitor |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| mon_o | output | 1 | Selected raw divider signal |
| lock_o | output | 1 | Alignment indicator |

## Verification
An input edge driven just after a falling clock edge shows on its output on the third rising clock edge that follows. The pulse width then depends only on the edge-to-edge offset in clocks. The lagging output lasts one clock. The driver queues the expected up/down widths for each comparison. A monitor samples on falling clock edges and compares each completed pulse pair against the queue. This makes the checks independent of absolute cycle numbers. Lock is sampled after the flags have settled, and once in the middle of a misaligned comparison to catch the drop while the leading output is still high. The monitor output is combinational and is checked one time step after its inputs change.

// File: rtl/pfd_pkg.sv
// Shared types for the polarity-selectable phase frequency detector.
package pfd_pkg;

    // Per-input edge index used by the synchroniser array
    localparam int unsigned IDX_REF = 0;
    localparam int unsigned IDX_VCO = 1;
    localparam int unsigned N_INPUTS = 2;

    // Comparison state: one flag per divided input
    typedef struct packed {
        logic ref_f;
        logic vco_f;
    } pfd_flags_t;

endpackage

// File: rtl/pfd_edge_det.sv
// Synchronises one asynchronous divider output into the clk domain and
// emits a single-clock pulse for each rising edge.
// Assumes the input stays at each level for more than SYNC_STAGES+1 clocks.
module pfd_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);

    logic sync_out;
    logic last_q;

    generate
        if (SYNC_STAGES <= 1) begin : g_single
            logic s_q;
            // Single capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= 1'b0;
                else        s_q <= d_i;
            end
            assign sync_out = s_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] s_q;
            // Shift chain of capture stages
            always_ff @(posedge clk) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= {s_q[SYNC_STAGES-2:0], d_i};
            end
            assign sync_out = s_q[SYNC_STAGES-1];
        end
    endgenerate

    // Previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_out;
    end

    assign rise_o = sync_out & ~last_q;

endmodule

// File: rtl/pfd_flags.sv
// Three-state comparison core: each edge pulse sets its flag; once both
// are set they are held one clock and then cleared together. A pulse
// arriving in the clearing clock starts the next comparison.
module pfd_flags
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_p_i,
    input  logic       vco_p_i,
    output pfd_flags_t flags_o
);

    pfd_flags_t flags_q;
    logic       both;

    assign both = flags_q.ref_f & flags_q.vco_f;

    // Set on edge pulse, clear one clock after both are set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q.ref_f <= both ? ref_p_i : (flags_q.ref_f | ref_p_i);
            flags_q.vco_f <= both ? vco_p_i : (flags_q.vco_f | vco_p_i);
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/pfd_lock.sv
// Lock qualifier: counts consecutive comparisons in which one flag stood
// alone for at most ALIGN_TOL clocks; raises lock after LOCK_CNT of them
// and drops it as soon as a flag stays alone longer.
module pfd_lock
    import pfd_pkg::*;
#(
    parameter int unsigned LOCK_CNT  = 16,
    parameter int unsigned ALIGN_TOL = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pfd_flags_t flags_i,
    output logic       lock_o
);

    localparam int unsigned GW = $clog2(LOCK_CNT + 1);
    localparam int unsigned WW = $clog2(ALIGN_TOL + 2);
    localparam logic [GW-1:0] GOOD_MAX  = GW'(LOCK_CNT);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_CNT - 1);
    localparam logic [WW-1:0] TOL_W     = WW'(ALIGN_TOL);

    logic [WW-1:0] alone_q;
    logic [GW-1:0] good_q;
    logic          bad_q;
    logic          lock_q;
    logic          alone;
    logic          both;
    logic          viol;

    assign alone = flags_i.ref_f ^ flags_i.vco_f;
    assign both  = flags_i.ref_f & flags_i.vco_f;
    assign viol  = alone && (alone_q >= TOL_W);

    // Saturating count of clocks a single flag has been set
    always_ff @(posedge clk) begin
        if (!rst_n)           alone_q <= '0;
        else if (!alone)      alone_q <= '0;
        else if (alone_q < TOL_W) alone_q <= alone_q + 1'b1;
    end

    // Remembers a violation until the comparison completes
    always_ff @(posedge clk) begin
        if (!rst_n)    bad_q <= 1'b0;
        else if (both) bad_q <= 1'b0;
        else if (viol) bad_q <= 1'b1;
    end

    // Run counter and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
            lock_q <= 1'b0;
        end else if (viol) begin
            good_q <= '0;
            lock_q <= 1'b0;
        end else if (both) begin
            if (bad_q) begin
                good_q <= '0;
                lock_q <= 1'b0;
            end else if (good_q >= GOOD_LAST) begin
                good_q <= GOOD_MAX;
                lock_q <= 1'b1;
            end else begin
                good_q <= good_q + 1'b1;
            end
        end
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/pfd_polsel.sv
// Top: polarity-selectable phase frequency detector with monitor mux and
// lock indicator. Both divider inputs are asynchronous to clk and must be
// slower than the synchroniser latency. pol_i is expected to be static
// while a comparison is in progress.
module pfd_polsel
    import pfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOCK_CNT    = 16,
    parameter int unsigned ALIGN_TOL   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_div_i,
    input  logic vco_div_i,
    input  logic pol_i,
    output logic up_o,
    output logic dn_o,
    output logic mon_o,
    output logic lock_o
);

    logic [N_INPUTS-1:0] raw_in;
    logic [N_INPUTS-1:0] rise_p;
    pfd_flags_t          flags;

    assign raw_in[IDX_REF] = ref_div_i;
    assign raw_in[IDX_VCO] = vco_div_i;

    // One synchroniser and edge detector per divided input
    generate
        for (genvar g = 0; g < N_INPUTS; g++) begin : g_in
            pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_i    (raw_in[g]),
                .rise_o (rise_p[g])
            );
        end
    endgenerate

    pfd_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_p_i (rise_p[IDX_REF]),
        .vco_p_i (rise_p[IDX_VCO]),
        .flags_o (flags)
    );

    pfd_lock #(.LOCK_CNT(LOCK_CNT), .ALIGN_TOL(ALIGN_TOL)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .lock_o  (lock_o)
    );

    // Polarity steering of the pump requests and the monitor
    always_comb begin
        if (pol_i) begin
            up_o  = flags.ref_f;
            dn_o  = flags.vco_f;
            mon_o = ref_div_i;
        end else begin
            up_o  = flags.vco_f;
            dn_o  = flags.ref_f;
            mon_o = vco_div_i;
        end
    end

endmodule

// File: rtl/pfd_polsel_chk.sv
// Port-level checker for pfd_polsel, attached by bind.
module pfd_polsel_chk #(
    parameter int unsigned ALIGN_TOL = 1
) (
    input logic clk,
    input logic rst_n,
    input logic up_o,
    input logic dn_o,
    input logic lock_o
);

    logic [7:0] solo_q;

    // Consecutive clocks with exactly one request high
    always_ff @(posedge clk) begin
        if (!rst_n)              solo_q <= '0;
        else if (!(up_o ^ dn_o)) solo_q <= '0;
        else if (solo_q != 8'hFF) solo_q <= solo_q + 1'b1;
    end

    // R1: reset clears all outputs
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!up_o && !dn_o && !lock_o));

    // R3 / R10: overlap of both requests lasts a single clock
    p_overlap_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && dn_o) |=> !(up_o && dn_o));

    // R8: lock only rises as a comparison completes
    p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(up_o && dn_o));

    // R9: lock drops once a lone request outlasts the tolerance
    p_lock_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_o ^ dn_o) && (32'(solo_q) >= ALIGN_TOL)) |=> !lock_o);

endmodule

bind pfd_polsel pfd_polsel_chk #(.ALIGN_TOL(ALIGN_TOL)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_o   (up_o),
    .dn_o   (dn_o),
    .lock_o (lock_o)
);

// File: tb/pfd_polsel_bench.sv
module pfd_polsel_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0;
    logic vco_div = 1'b0;
    logic pol = 1'b1;
    logic up, dn, mon, lock;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        int    up_w;
        int    dn_w;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    pfd_polsel #(.SYNC_STAGES(2), .LOCK_CNT(4), .ALIGN_TOL(1)) u_pfd_polsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_div_i (ref_div),
        .vco_div_i (vco_div),
        .pol_i     (pol),
        .up_o      (up),
        .dn_o      (dn),
        .mon_o     (mon),
        .lock_o    (lock)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Monitor: measure each up/down pulse pair and pop its expectation
    initial begin
        int   uw;
        int   dw;
        bit   busy;
        exp_t e;
        uw = 0; dw = 0; busy = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                uw = 0; dw = 0; busy = 0;
            end else if (up || dn) begin
                busy = 1;
                uw += int'(up);
                dw += int'(dn);
            end else if (busy) begin
                busy = 0;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected pulse up width", uw, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk(uw == e.up_w, e.tag, "up width", uw, e.up_w);
                    chk(dw == e.dn_w, e.tag, "dn width", dw, e.dn_w);
                end
                uw = 0; dw = 0;
            end
        end
    end

    // Driver: one comparison; d > 0 means reference leads by d clocks
    task automatic compare(input int d, input string tag, input bit chk_drop);
        int   a;
        int   ref_w;
        int   vco_w;
        int   busy_cnt;
        exp_t e;
        a     = (d < 0) ? -d : d;
        ref_w = (d >= 0) ? a + 1 : 1;
        vco_w = (d <= 0) ? a + 1 : 1;
        e.up_w = pol ? ref_w : vco_w;
        e.dn_w = pol ? vco_w : ref_w;
        e.tag  = tag;
        sb_q.push_back(e);
        @(negedge clk);
        if (d >= 0) ref_div = 1'b1;
        if (d <= 0) vco_div = 1'b1;
        repeat (a) @(negedge clk);
        if (d > 0) vco_div = 1'b1;
        if (d < 0) ref_div = 1'b1;
        if (chk_drop) begin
            repeat (2) @(negedge clk);
            // R9: lock gone while the leading request is still alone
            chk(lock == 1'b0 && up == 1'b1 && dn == 1'b0, "R9",
                "lock during lone up", int'(lock), 0);
        end
        repeat (8) @(negedge clk);
        ref_div = 1'b0;
        vco_div = 1'b0;
        busy_cnt = 0;
        repeat (6) begin
            @(negedge clk);
            busy_cnt += int'(up || dn);
        end
        // R7: falling edges and steady levels raise no request
        chk(busy_cnt == 0, "R7", "requests after falling edges", busy_cnt, 0);
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        exp_t e;
        // R1: reset state, and R5 monitor steering checked while in reset
        repeat (3) @(negedge clk);
        chk(!up && !dn && !lock, "R1", "outputs in reset", int'({up, dn, lock}), 0);
        ref_div = 1'b1; vco_div = 1'b0; pol = 1'b1; #1;
        chk(mon == 1'b1, "R5", "mon pol=1 ref=1", int'(mon), 1);
        pol = 1'b0; #1;
        chk(mon == 1'b0, "R5", "mon pol=0 vco=0", int'(mon), 0);
        ref_div = 1'b0; vco_div = 1'b1; #1;
        chk(mon == 1'b1, "R5", "mon pol=0 vco=1", int'(mon), 1);
        pol = 1'b1; #1;
        chk(mon == 1'b0, "R5", "mon pol=1 ref=0", int'(mon), 0);
        vco_div = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!up && !dn && !lock, "R1", "outputs after reset", int'({up, dn, lock}), 0);

        // R6 latency and R2 widths, reference leads by one clock
        e.up_w = 2; e.dn_w = 1; e.tag = "R2";
        sb_q.push_back(e);
        ref_div = 1'b1;
        @(negedge clk);
        vco_div = 1'b1;
        @(negedge clk);
        chk(up == 1'b0, "R6", "up after two edges", int'(up), 0);
        @(negedge clk);
        chk(up == 1'b1 && dn == 1'b0, "R6", "up after three edges", int'(up), 1);
        repeat (8) @(negedge clk);
        ref_div = 1'b0; vco_div = 1'b0;
        repeat (6) @(negedge clk);

        // R10 simultaneous edges, R2 oscillator leading
        compare(0, "R10", 1'b0);
        compare(-1, "R2", 1'b0);
        chk(lock == 1'b0, "R8", "lock after 3 aligned", int'(lock), 0);

        // R4 inverted polarity, fourth aligned comparison sets lock
        pol = 1'b0;
        compare(1, "R4", 1'b0);
        chk(lock == 1'b1, "R8", "lock after 4 aligned", int'(lock), 1);
        compare(-1, "R4", 1'b0);

        // R9 misaligned comparison drops lock
        pol = 1'b1;
        compare(3, "R9", 1'b1);
        chk(lock == 1'b0, "R9", "lock after misaligned", int'(lock), 0);

        // R8 run restarts from zero
        compare(0, "R8", 1'b0);
        compare(1, "R8", 1'b0);
        compare(-1, "R8", 1'b0);
        chk(lock == 1'b0, "R8", "lock after 3 of new run", int'(lock), 0);
        compare(0, "R8", 1'b0);
        chk(lock == 1'b1, "R8", "lock after 4 of new run", int'(lock), 1);

        chk(sb_q.size() == 0, "R3", "pending expectations", sb_q.size(), 0);
        summary();
        $finish;
    end

endmodule